// File: doc/BRIEF.md
# DTMF Tone Timing Generator

This block turns a dial key into the two square-wave tones of a dual-tone digit. Both tones come from a single fast system clock, nominally 3.579545 MHz, through fixed integer half-period dividers. The resulting frequencies sit slightly off the nominal tone plan but stay well inside its tolerance. A key press is a request level (`req_i`) together with a row index, a column index and two enables. With the enables the block can play the row tone alone, the column tone alone, both, or neither.

The sequencer guarantees a minimum tone-on time and a minimum silent time after each burst. A burst that is held past its minimum keeps sounding until the key is released. A new press that arrives during a burst or during the following gap is not lost. It is parked in a one-deep slot and played as soon as the gap ends. `busy_o` stays high from the start of a burst until the end of its gap. In pulse-dialing mode both tone outputs are held low, while the timing keeps running unchanged. An analog summing stage and digit storage sit outside this block.

Top module: `dtmf_tone_gen`

## Requirements
- R1: After reset, and at once when the active-low asynchronous reset is asserted during a burst, `busy_o`, `row_tone_o` and `col_tone_o` are all 0.
- R2: When `req_i` is sampled high while the block is idle, `busy_o` is 1 from the next cycle, and the burst starts with the enabled tones high in that cycle.
- R3: `row_i` selects a row tone by index 0 to 3. During a burst the row tone is a square wave that starts high and toggles every `ROW_HALF[row]` cycles.
- R4: `col_i` selects a column tone by index 0 to 2. The column tone toggles every `COL_HALF[col]` cycles and starts high. Column code 3 produces no column tone.
- R5: `row_i`, `col_i`, `row_on_i` and `col_on_i` are captured when a burst starts, and later changes do not affect that burst. A disabled tone stays 0, which gives dual, single or silent bursts.
- R6: A burst whose request is released before the minimum lasts exactly `ON_CYC` cycles.
- R7: While `req_i` stays high the burst continues. The burst ends at the first clock edge at or after `ON_CYC` cycles where `req_i` is sampled low.
- R8: After every burst follows a gap of exactly `OFF_CYC` cycles. During the gap `busy_o` is 1 and both tones are 0. After the gap the block goes idle if nothing is pending.
- R9: A rising edge of `req_i` during a burst or gap captures the inputs present at that edge into a pending slot, and a later rising edge overwrites them. A burst with the pending code starts in the cycle right after the gap ends.
- R10: While `pulse_mode_i` is 1, both tone outputs are 0. Burst and gap timing and `busy_o` behave as in tone mode.
- R11: With the default dividers and a 3.579545 MHz clock, every row and column tone is within 0.8 % of its nominal frequency. The nominal row tones are 697, 770, 852 and 941 Hz, and the nominal column tones are 1209, 1336 and 1477 Hz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_mode_i | input | 1 | 1 selects pulse dialing, which silences both tones |
| req_i | input | 1 | Key held / tone request level |
| row_i | input | 2 | Row tone index |
| col_i | input | 2 | Column tone index, 3 means no column tone |
| row_on_i | input | 1 | Enable row tone for this press |
| col_on_i | input | 1 | Enable column tone for this press |
| row_tone_o | output | 1 | Row tone square wave |
| col_tone_o | output | 1 | Column tone square wave |
| busy_o | output | 1 | Burst or gap in progress |

## Verification
The hardest state to reach is the pending slot being overwritten and then replayed. The stimulus needs a release before the minimum burst ends, then a new press while the first burst is still sounding, with different inputs on the row and column pins. A further press has to land inside the gap. The bench scripts this sequence cycle by cycle. It confirms that the running burst keeps its captured code and that the burst after the gap plays the last press rather than the first. A second instance with the default dividers is held on each tone long enough to measure a full period, and the bench converts that period to a frequency to check the tolerance.

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen #(
  parameter int unsigned ON_CYC  = 332898,
  parameter int unsigned OFF_CYC = 332898,
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned ROW_HALF [4] = '{2560, 2336, 2110, 1888},
  parameter int unsigned COL_HALF [3] = '{1472, 1344, 1216}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_mode_i,
  input  logic       req_i,
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  input  logic       row_on_i,
  input  logic       col_on_i,
  output logic       row_tone_o,
  output logic       col_tone_o,
  output logic       busy_o
);

  localparam int unsigned MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_GAP} st_t;

  st_t             st_q;
  logic [TW-1:0]   tmr_q;
  logic            req_q;
  logic            pend_q;
  logic [1:0]      prow_q, pcol_q, row_q, col_q;
  logic            pron_q, pcon_q, ron_q, con_q;
  logic [DIV_W-1:0] rcnt_q, ccnt_q, rhalf, chalf;
  logic            rsq_q, csq_q;
  logic            in_burst, in_gap, rise, on_done, off_done, start;

  assign in_burst = (st_q == S_BURST);
  assign in_gap   = (st_q == S_GAP);
  assign busy_o   = (st_q != S_IDLE);
  assign rise     = req_i & ~req_q;
  assign on_done  = in_burst && (tmr_q >= TW'(ON_CYC - 1)) && !req_i;
  assign off_done = in_gap && (tmr_q >= TW'(OFF_CYC - 1));
  assign start    = ((st_q == S_IDLE) && req_i) || (off_done && (pend_q || req_i));

  assign rhalf = DIV_W'(ROW_HALF[row_q]);
  assign chalf = col_q[1] ? DIV_W'(COL_HALF[2]) :
                 col_q[0] ? DIV_W'(COL_HALF[1]) : DIV_W'(COL_HALF[0]);

  assign row_tone_o = in_burst & ron_q & rsq_q & ~pulse_mode_i;
  assign col_tone_o = in_burst & con_q & (col_q != 2'd3) & csq_q & ~pulse_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tmr_q  <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      prow_q <= '0;
      pcol_q <= '0;
      pron_q <= 1'b0;
      pcon_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      ron_q  <= 1'b0;
      con_q  <= 1'b0;
    end else begin
      req_q <= req_i;
      unique case (st_q)
        S_IDLE: begin
          if (req_i) begin
            st_q  <= S_BURST;
            tmr_q <= '0;
            row_q <= row_i;
            col_q <= col_i;
            ron_q <= row_on_i;
            con_q <= col_on_i;
          end
        end
        S_BURST: begin
          if (on_done) begin
            st_q  <= S_GAP;
            tmr_q <= '0;
          end else if (tmr_q < TW'(ON_CYC - 1)) begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        S_GAP: begin
          if (off_done) begin
            tmr_q <= '0;
            if (start) begin
              st_q   <= S_BURST;
              pend_q <= 1'b0;
              row_q  <= pend_q ? prow_q : row_i;
              col_q  <= pend_q ? pcol_q : col_i;
              ron_q  <= pend_q ? pron_q : row_on_i;
              con_q  <= pend_q ? pcon_q : col_on_i;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if ((in_burst || in_gap) && rise && !start) begin
        pend_q <= 1'b1;
        prow_q <= row_i;
        pcol_q <= col_i;
        pron_q <= row_on_i;
        pcon_q <= col_on_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      ccnt_q <= '0;
      rsq_q  <= 1'b1;
      csq_q  <= 1'b1;
    end else if (!in_burst) begin
      rcnt_q <= '0;
      ccnt_q <= '0;
      rsq_q  <= 1'b1;
      csq_q  <= 1'b1;
    end else begin
      if (rcnt_q == rhalf - 1'b1) begin
        rcnt_q <= '0;
        rsq_q  <= ~rsq_q;
      end else begin
        rcnt_q <= rcnt_q + 1'b1;
      end
      if (ccnt_q == chalf - 1'b1) begin
        ccnt_q <= '0;
        csq_q  <= ~csq_q;
      end else begin
        ccnt_q <= ccnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dtmf_tone_gen_chk.sv
module dtmf_tone_gen_chk #(
  parameter int unsigned ON_CYC  = 1,
  parameter int unsigned OFF_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_mode_i,
  input logic req_i,
  input logic in_burst,
  input logic in_gap,
  input logic busy_o,
  input logic row_tone_o,
  input logic col_tone_o
);

  int unsigned on_cnt, off_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt  <= 0;
      off_cnt <= 0;
    end else begin
      on_cnt  <= !in_burst ? 0 : (on_cnt  == 32'hFFFF_FFFF ? on_cnt  : on_cnt  + 1);
      off_cnt <= !in_gap   ? 0 : (off_cnt == 32'hFFFF_FFFF ? off_cnt : off_cnt + 1);
    end
  end

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);

  p_min_burst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_burst) |-> (on_cnt >= ON_CYC));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_burst && req_i) |=> in_burst);

  p_gap_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_gap) |-> (off_cnt == OFF_CYC));

  p_gap_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_gap || !busy_o) |-> (!row_tone_o && !col_tone_o));

  p_after_burst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_burst) |-> in_gap);

  p_pulse_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode_i |-> (!row_tone_o && !col_tone_o));

endmodule

bind dtmf_tone_gen dtmf_tone_gen_chk #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pulse_mode_i(pulse_mode_i), .req_i(req_i),
  .in_burst(in_burst), .in_gap(in_gap), .busy_o(busy_o),
  .row_tone_o(row_tone_o), .col_tone_o(col_tone_o));

// File: tb/dtmf_tone_gen_tb_top.sv
module dtmf_tone_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ON  = 40;
  localparam int OFF = 30;
  localparam int RH [4] = '{5, 6, 7, 9};
  localparam int CH [3] = '{2, 3, 4};
  localparam int WD_CYC = 150000;
  // {row[1:0], col[1:0], row_on, col_on}
  localparam logic [5:0] VEC [8] = '{
    6'b00_00_11, 6'b01_01_11, 6'b10_10_11, 6'b11_00_11,
    6'b10_01_10, 6'b00_10_01, 6'b01_11_11, 6'b11_10_00};
  localparam real NOM_R [4] = '{697.0, 770.0, 852.0, 941.0};
  localparam real NOM_C [3] = '{1209.0, 1336.0, 1477.0};

  logic clk = 0, rst_n = 0, pm = 0, req = 0, req_f = 0;
  logic [1:0] row = 0, col = 0;
  logic ron = 0, con = 0;
  logic rt, ct, busy, rtf, ctf, busyf;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_tone_gen #(.ON_CYC(ON), .OFF_CYC(OFF), .DIV_W(8),
    .ROW_HALF('{5, 6, 7, 9}), .COL_HALF('{2, 3, 4})) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_mode_i(pm), .req_i(req), .row_i(row), .col_i(col),
    .row_on_i(ron), .col_on_i(con), .row_tone_o(rt), .col_tone_o(ct), .busy_o(busy));

  dtmf_tone_gen #(.ON_CYC(20), .OFF_CYC(20)) dut_f_i (
    .clk_i(clk), .rst_ni(rst_n), .pulse_mode_i(pm), .req_i(req_f), .row_i(row), .col_i(col),
    .row_on_i(ron), .col_on_i(con), .row_tone_o(rtf), .col_tone_o(ctf), .busy_o(busyf));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 R11: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_r(int i, int r, bit ro);
    if (!ro) return 1'b0;
    return ((i / RH[r]) % 2) == 0;
  endfunction

  function automatic bit exp_c(int i, int c, bit co);
    if (!co || c == 3) return 1'b0;
    return ((i / CH[c]) % 2) == 0;
  endfunction

  task automatic sample_b(int i, int r, int c, bit ro, bit co, string tag);
    bit er, ec;
    er = exp_r(i, r, ro);
    ec = exp_c(i, c, co);
    chk(rt == er && ct == ec && busy, tag, $sformatf("burst cycle %0d {row,col,busy}", i),
        {rt, ct, busy}, {er, ec, 1'b1});
  endtask

  task automatic drive(int r, int c, bit ro, bit co);
    row = 2'(r); col = 2'(c); ron = ro; con = co; req = 1;
  endtask

  task automatic gap_then(bit expect_idle);
    for (int j = 0; j < OFF; j++) begin
      chk(busy && !rt && !ct, "R8", "gap {row,col,busy}", {rt, ct, busy}, 1);
      @(negedge clk);
    end
    if (expect_idle) chk(!busy && !rt && !ct, "R8", "idle after gap {row,col,busy}", {rt, ct, busy}, 0);
  endtask

  task automatic burst_and_gap(int r, int c, bit ro, bit co, int hold, string tag);
    int len;
    len = (hold > ON) ? hold : ON;
    drive(r, c, ro, co);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      sample_b(i, r, c, ro, co, tag);
      if (i == hold - 1) req = 0;
      @(negedge clk);
    end
    gap_then(1);
  endtask

  task automatic measure(bit use_col, int idx, string tag);
    int hi, lo;
    real f, nom, err;
    if (use_col) begin row = 0; col = 2'(idx); ron = 0; con = 1; nom = NOM_C[idx]; end
    else         begin row = 2'(idx); col = 0; ron = 1; con = 0; nom = NOM_R[idx]; end
    req_f = 1;
    @(negedge clk);
    hi = 0; lo = 0;
    while ((use_col ? ctf : rtf) == 1'b1) begin hi++; @(negedge clk); end
    while ((use_col ? ctf : rtf) == 1'b0) begin lo++; @(negedge clk); end
    f = 3579545.0 / real'(hi + lo);
    err = (f - nom) / nom * 100.0;
    if (err < 0.0) err = -err;
    chk(err <= 0.8 && hi == lo, tag, $sformatf("frequency x10 (period %0d)", hi + lo),
        int'(f * 10.0), int'(nom * 10.0));
    req_f = 0;
    while (busyf) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !rt && !ct, "R1", "in reset {row,col,busy}", {rt, ct, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rt && !ct, "R1", "after reset {row,col,busy}", {rt, ct, busy}, 0);

    // table: R2 R3 R4 R5 R6 across codes
    foreach (VEC[v])
      burst_and_gap(int'(VEC[v][5:4]), int'(VEC[v][3:2]), VEC[v][1], VEC[v][0], 1, "R2 R3 R4 R5 R6");

    // R7: held past minimum, and held exactly the minimum
    burst_and_gap(3, 2, 1, 1, ON + 10, "R7");
    burst_and_gap(1, 0, 1, 1, ON, "R7");

    // R9: pending press during burst, overwritten during gap; R5 active code kept
    drive(0, 0, 1, 1);
    @(negedge clk);
    for (int i = 0; i < ON; i++) begin
      sample_b(i, 0, 0, 1, 1, "R5 R9");
      if (i == 0) req = 0;
      if (i == 10) drive(2, 1, 1, 1);
      if (i == 11) req = 0;
      @(negedge clk);
    end
    for (int j = 0; j < OFF; j++) begin
      chk(busy && !rt && !ct, "R8 R9", "gap with pending {row,col,busy}", {rt, ct, busy}, 1);
      if (j == 5) drive(3, 2, 1, 0);
      if (j == 6) req = 0;
      @(negedge clk);
    end
    for (int i = 0; i < ON; i++) begin
      sample_b(i, 3, 2, 1, 0, "R9");
      @(negedge clk);
    end
    gap_then(1);

    // R10: pulse mode silences tones, timing unchanged
    pm = 1;
    drive(2, 1, 1, 1);
    @(negedge clk);
    for (int i = 0; i < ON; i++) begin
      chk(busy && !rt && !ct, "R10", "pulse mode burst {row,col,busy}", {rt, ct, busy}, 1);
      if (i == 0) req = 0;
      @(negedge clk);
    end
    gap_then(1);
    pm = 0;

    // R1: asynchronous reset during a burst
    drive(1, 1, 1, 1);
    @(negedge clk);
    req = 0;
    repeat (5) @(negedge clk);
    rst_n = 0;
    #1;
    chk(!busy && !rt && !ct, "R1", "reset mid-burst {row,col,busy}", {rt, ct, busy}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1", "idle after mid-burst reset", busy, 0);
    burst_and_gap(0, 1, 1, 1, 1, "R2");

    // R11: default dividers against nominal frequencies
    for (int r = 0; r < 4; r++) measure(1'b0, r, "R11 row");
    for (int c = 0; c < 3; c++) measure(1'b1, c, "R11 col");

    summary();
    $finish;
  end
endmodule